// File: doc/BRIEF.md
# Vehicle-Bus Controller Interrupt Unit

This block gathers the single-cycle event strobes produced by a byte-level vehicle-bus protocol controller and turns them into one interrupt request toward a CPU. Eight sources are tracked. The error source merges eight separate error strobes. The transmit-ready source merges two strobes: the opcode holding register has room, and the transmit sequencer has taken an opcode. The other six sources map one to one: byte received, lost arbitration, end-of-data, end-of-frame, DMA receive end-of-block and DMA transmit end-of-block. Each source has a pending bit that an event sets, and an enable bit that software controls.

Software uses a four-word synchronous register bus to clear pending bits, set enables, load a vector base and set a 3-bit unit priority level. The level is presented to the system interrupt controller, where 0 is the most urgent. The all-ones level can never be acknowledged, so the unit drops its request while that level is set. Among its own sources the unit applies a fixed ranking. The vector it presents is the vector base plus twice the rank index of the highest-ranked active source.

Top module: `busirq_ctrl`

## Requirements
- R1: After reset, pending = 0x00, enable = 0x00, vector base = 0x00, level = 3'b111, and `irq` is low.
- R2: Each of these strobes sets its pending bit one clock after the cycle in which it is high: lost arbitration → bit 1, byte received → bit 2, end-of-frame → bit 4, end-of-data → bit 5, DMA receive end-of-block → bit 6, DMA transmit end-of-block → bit 7.
- R3: Any bit of the 8-bit `ev_err` vector sets pending bit 0 (the error source).
- R4: Either `ev_tx_room` or `ev_tx_taken` sets pending bit 3 (the transmit-ready source).
- R5: Writing address 0 clears every pending bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R6: If a clear of a pending bit and an event for that same bit occur in the same cycle, the bit ends up cleared.
- R7: `irq` is high exactly when (pending AND enable) is non-zero and the level is not 3'b111. A pending bit whose enable bit is 0 does not raise `irq`.
- R8: Setting the enable bit of a source whose pending bit is already 1 raises `irq` in the cycle after the write.
- R9: While `irq` is high, `irq_vec` = (vector base + 2 × i) mod 256, where i is the lowest-numbered bit that is both pending and enabled. The ranking from bit 0 to bit 7 is: error, lost arbitration, byte received, transmit ready, end-of-frame, end-of-data, DMA receive end-of-block, DMA transmit end-of-block.
- R10: Level 3'b111 blocks `irq` but pending bits still record events. `irq_level` always shows the level register.
- R11: The register map, read back combinationally on `bus_rdata`, is: address 0 pending (write 1 to clear), address 1 enable, address 2 vector base, address 3 level in bits 2:0 (bits 7:3 read as 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rx_byte | input | 1 | Complete byte placed in the receive register |
| ev_tx_room | input | 1 | Opcode register can accept a new opcode |
| ev_tx_taken | input | 1 | Transmit sequencer took an opcode |
| ev_lost_arb | input | 1 | Transmitter lost arbitration |
| ev_end_data | input | 1 | Passive level exceeded the minimum end-of-data time |
| ev_end_frame | input | 1 | Passive level exceeded the minimum end-of-frame time |
| ev_dma_rx_eob | input | 1 | Last byte of a DMA receive block was read |
| ev_dma_tx_eob | input | 1 | Last byte of a DMA transmit block was written |
| ev_err | input | 8 | Individual error strobes, merged into one source |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector of the highest-ranked active source |
| irq_level | output | 3 | Unit priority level |

## Verification
The hardest case to create from the ports is an event strobe and a write-one clear landing on the same pending bit in the same clock. The bench lines both up on one falling edge, so the rising edge samples them together. It then reads the pending register back to confirm the bit stayed clear. The bench also reaches vector-base wraparound by loading a base near 0xFF while only the lowest-ranked source is active. It shows that a pending but disabled source is held back by setting that bit, then reading `irq` before and after the enable write.

// File: rtl/busirq_ctrl.sv
module busirq_ctrl #(
  parameter int ERR_N = 8,
  parameter int DW    = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rx_byte,
  input  logic             ev_tx_room,
  input  logic             ev_tx_taken,
  input  logic             ev_lost_arb,
  input  logic             ev_end_data,
  input  logic             ev_end_frame,
  input  logic             ev_dma_rx_eob,
  input  logic             ev_dma_tx_eob,
  input  logic [ERR_N-1:0] ev_err,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq,
  output logic [DW-1:0]    irq_vec,
  output logic [LVL_W-1:0] irq_level
);
  localparam int NSRC = 8;
  localparam int IW   = $clog2(NSRC);
  localparam logic [LVL_W-1:0] LVL_OFF = '1;

  logic [NSRC-1:0]  pend, mask, ev_vec, act, clr;
  logic [DW-1:0]    vbase;
  logic [LVL_W-1:0] level;
  logic [IW-1:0]    win;
  logic             wr;

  assign wr  = bus_sel && bus_we;
  assign clr = (wr && bus_addr == 2'd0) ? bus_wdata[NSRC-1:0] : '0;

  assign ev_vec = {ev_dma_tx_eob, ev_dma_rx_eob, ev_end_data, ev_end_frame,
                   ev_tx_room | ev_tx_taken, ev_rx_byte, ev_lost_arb, |ev_err};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      mask  <= '0;
      vbase <= '0;
      level <= LVL_OFF;
    end else begin
      pend <= (pend | ev_vec) & ~clr;
      if (wr && bus_addr == 2'd1) mask  <= bus_wdata[NSRC-1:0];
      if (wr && bus_addr == 2'd2) vbase <= bus_wdata;
      if (wr && bus_addr == 2'd3) level <= bus_wdata[LVL_W-1:0];
    end
  end

  assign act = pend & mask;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i]) win = IW'(i);
  end

  assign irq       = (|act) && (level != LVL_OFF);
  assign irq_vec   = vbase + DW'({win, 1'b0});
  assign irq_level = level;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = DW'(pend);
      2'd1:    bus_rdata = DW'(mask);
      2'd2:    bus_rdata = vbase;
      default: bus_rdata = DW'(level);
    endcase
  end
endmodule

module busirq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_lost_arb,
  input logic [7:0] ev_err,
  input logic       ev_tx_room,
  input logic       ev_tx_taken,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       irq,
  input logic [7:0] irq_vec,
  input logic [2:0] irq_level,
  input logic [7:0] pend,
  input logic [7:0] mask,
  input logic [7:0] vbase
);
  logic wr0;
  assign wr0 = bus_sel && bus_we && bus_addr == 2'd0;

  // R2
  arb_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lost_arb && !(wr0 && bus_wdata[1])) |=> pend[1]);

  // R3
  err_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev_err) && !(wr0 && bus_wdata[0])) |=> pend[0]);

  // R4
  trdy_either_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_tx_room || ev_tx_taken) && !(wr0 && bus_wdata[3])) |=> pend[3]);

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && bus_wdata[1]) |=> !pend[1]);

  // R10
  level_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 3'b111) |-> !irq);

  // R7
  irq_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & mask) != 8'h00));

  // R9
  top_rank_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && pend[0] && mask[0]) |-> (irq_vec == vbase));
endmodule

bind busirq_ctrl busirq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_lost_arb(ev_lost_arb), .ev_err(ev_err),
  .ev_tx_room(ev_tx_room), .ev_tx_taken(ev_tx_taken),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq(irq), .irq_vec(irq_vec), .irq_level(irq_level),
  .pend(pend), .mask(mask), .vbase(vbase)
);

// File: tb/tb_busirq_ctrl.sv
module tb_busirq_ctrl;
  logic clk = 0, rst_n = 0;
  logic ev_rx_byte = 0, ev_tx_room = 0, ev_tx_taken = 0, ev_lost_arb = 0;
  logic ev_end_data = 0, ev_end_frame = 0, ev_dma_rx_eob = 0, ev_dma_tx_eob = 0;
  logic [7:0] ev_err = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, irq_vec;
  logic irq;
  logic [2:0] irq_level;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  busirq_ctrl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(int which, logic [7:0] err);
    @(negedge clk);
    case (which)
      0: ev_err = err;
      1: ev_lost_arb = 1;
      2: ev_rx_byte = 1;
      3: ev_tx_room = 1;
      4: ev_end_frame = 1;
      5: ev_end_data = 1;
      6: ev_dma_rx_eob = 1;
      7: ev_dma_tx_eob = 1;
      8: ev_tx_taken = 1;
      default: ;
    endcase
    @(negedge clk);
    ev_err = 0; ev_lost_arb = 0; ev_rx_byte = 0; ev_tx_room = 0; ev_tx_taken = 0;
    ev_end_frame = 0; ev_end_data = 0; ev_dma_rx_eob = 0; ev_dma_tx_eob = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); check("R1 pending", d, 8'h00);
    rd(1, d); check("R1 enable", d, 8'h00);
    rd(2, d); check("R1 base", d, 8'h00);
    rd(3, d); check("R11 level readback", d, 8'h07);
    check("R1 irq", irq, 0);
    check("R1 level", irq_level, 3'b111);
  endtask

  task automatic t_sources();
    logic [7:0] d;
    for (int s = 1; s < 8; s++) begin
      pulse(s, 0); rd(0, d);
      check("R2 source bit", d, 8'h01 << s);
      wr(0, 8'hFF);
    end
    for (int e = 0; e < 8; e++) begin
      pulse(0, 8'h01 << e); rd(0, d);
      check("R3 error fold", d, 8'h01);
      wr(0, 8'hFF);
    end
    pulse(8, 0); rd(0, d); check("R4 tx taken", d, 8'h08); wr(0, 8'hFF);
    pulse(3, 0); rd(0, d); check("R4 tx room", d, 8'h08); wr(0, 8'hFF);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    pulse(2, 0); pulse(5, 0); pulse(7, 0);
    wr(0, 8'h00); rd(0, d); check("R5 write zero keeps", d, 8'hA4);
    wr(0, 8'h20); rd(0, d); check("R5 partial clear", d, 8'h84);
    wr(0, 8'hFF); rd(0, d); check("R5 full clear", d, 8'h00);
  endtask

  task automatic t_clear_wins();
    logic [7:0] d;
    @(negedge clk);
    ev_lost_arb = 1; bus_sel = 1; bus_we = 1; bus_addr = 0; bus_wdata = 8'h02;
    @(negedge clk);
    ev_lost_arb = 0; bus_sel = 0; bus_we = 0;
    rd(0, d); check("R6 clear wins", d, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(3, 8'h00);
    check("R10 level shown", irq_level, 3'b000);
    pulse(2, 0);
    check("R7 disabled source quiet", irq, 0);
    wr(1, 8'h04);
    check("R8 unmask raises", irq, 1);
    wr(3, 8'h07);
    check("R10 level off blocks", irq, 0);
    pulse(4, 0); rd(0, d);
    check("R10 pending still records", d, 8'h14);
    wr(3, 8'h02);
    check("R7 request back", irq, 1);
    wr(0, 8'hFF); wr(1, 8'h00);
    check("R7 cleared drops", irq, 0);
  endtask

  task automatic t_vector();
    wr(2, 8'h40); wr(1, 8'hFF);
    pulse(5, 0); pulse(3, 0); pulse(7, 0);
    check("R9 winner bit3", irq_vec, 8'h46);
    wr(0, 8'h08);
    check("R9 winner bit5", irq_vec, 8'h4A);
    check("R7 stays while active", irq, 1);
    pulse(0, 8'h80);
    check("R9 error top rank", irq_vec, 8'h40);
    wr(0, 8'h21);
    wr(2, 8'hFC);
    check("R9 wrap", irq_vec, 8'h0A);
    wr(0, 8'h80);
    check("R7 all cleared", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sources();
    t_w1c();
    t_clear_wins();
    t_gate();
    t_vector();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule